// File: doc/BRIEF.md
# eMMC Boot Mode Sequencer

This block drives the command line and takes in the single-bit data line of an MMC host while a card boots. It has two ways into boot. In primary entry the command line is pulled low at start and kept low until the read ends. In alternate entry the block first shifts out a 48-bit command-zero frame that carries the boot argument, waits for no response, and goes straight on to receive data. Both entries may first look for a boot acknowledge token on the data line. They then collect a programmed number of 512-byte blocks, which are handed out one byte at a time with a valid strobe.

A start pulse, given while the block is idle, launches an operation. The operation ends with a one-cycle done pulse, with the error flag when the acknowledge is missing or wrong, or early when the soft-terminate input rises. When the boot-operation input is low, the run is a plain block read: the command line stays high and the acknowledge enable and mode inputs have no effect.

Top module: `emmc_boot_seq`

## Requirements
- R1: With bootOp=1 and altMode=0 (primary entry), cmdOut is 0 from the cycle after the start pulse up to and including the cycle done is high. While idle, including after reset, cmdOut is 1.
- R2: With bootOp=1 and altMode=1, cmdOut presents a 48-bit frame, MSB first, one bit per clock, starting the cycle after start. The frame is, from first bit to last: 0, 1, six zero index bits, argument 0xFFFFFFFA, CRC7 (polynomial x^7+x^3+1 over the first 40 bits, register starting at zero), and 1. cmdOut is 1 afterwards.
- R3: Each block begins with a 0 start bit on dat0. The next 4096 bits are packed MSB first into bytes, and each byte is output on rxByte with a one-cycle rxValid. The block count is blockCount, and a value of 0 gives one block.
- R4: When bootOp=1 and ackEn=1, the block waits for an acknowledge before data: a 0 start bit followed by the bits 0,1,0,1. A start bit sampled within ackTimeout cycles of entering the wait is accepted.
- R5: If no acknowledge start bit arrives within ackTimeout cycles, err becomes 1, done does not pulse, cmdOut returns to 1 and the block goes idle.
- R6: If the four bits after the acknowledge start bit are not 0,1,0,1, err becomes 1 and the block goes idle with cmdOut 1.
- R7: With bootOp=0, altMode and ackEn are ignored. No frame is sent, cmdOut stays 1, and data blocks are read directly.
- R8: A rising edge on softTerm during an operation ends it at once: no done, no further bytes, cmdOut 1. A softTerm held high does not end later operations.
- R9: One cycle after the last data bit is sampled, done is high for exactly one cycle, and then the block is idle. err is cleared by each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse, taken only while idle |
| bootOp | input | 1 | 1 = boot operation, 0 = plain block read |
| altMode | input | 1 | 1 = alternate entry (frame), 0 = primary entry (held low) |
| ackEn | input | 1 | Expect a boot acknowledge before data |
| blockCount | input | BLK_W | Number of blocks to read (0 reads one) |
| ackTimeout | input | TO_W | Acknowledge wait limit in clock cycles |
| softTerm | input | 1 | Terminate on rising edge |
| dat0 | input | 1 | Serial data line from the card |
| cmdOut | output | 1 | Command line drive level |
| rxByte | output | 8 | Received byte |
| rxValid | output | 1 | rxByte is valid this cycle |
| done | output | 1 | Operation completed (one cycle) |
| err | output | 1 | Acknowledge missing or malformed; held until next start |

## Verification
The assertions rely on dat0, start and softTerm being synchronous to clk and stable around its rising edge, on start arriving only while the block is idle, and on ackTimeout being nonzero. The bench drives every input on the falling edge and launches an operation only after the previous one has finished or failed. It picks timeouts between 8 and 40 cycles and places each random acknowledge delay strictly inside the window, with directed cases at a zero delay, at the last accepted cycle and past the limit.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

  localparam int FRAME_LEN = 48;
  localparam logic [31:0] BOOT_ARG = 32'hFFFF_FFFA;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ACKWAIT, S_ACKBITS, S_BLKWAIT, S_DATA, S_DONE
  } seqStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic shiftFrame;
    logic driveFrame;
    logic holdLow;
    logic clearData;
    logic shiftData;
  } dpCtlT;

  function automatic logic [6:0] crc7(input logic [39:0] msg);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = msg[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [FRAME_LEN-1:0] bootFrame();
    logic [39:0] m;
    m = {2'b01, 6'd0, BOOT_ARG};
    return {m, crc7(m), 1'b1};
  endfunction

endpackage

// File: rtl/emmc_boot_dp.sv
module emmc_boot_dp
  import emmc_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtlT      ctl,
  input  logic       dat0,
  output logic       cmdOut,
  output logic [7:0] rxByte,
  output logic       rxValid
);

  logic [FRAME_LEN-1:0] frameSh;
  logic [6:0]           dataSh;
  logic [2:0]           bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSh <= '1;
      dataSh  <= '0;
      bitCnt  <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (ctl.loadFrame)       frameSh <= bootFrame();
      else if (ctl.shiftFrame) frameSh <= {frameSh[FRAME_LEN-2:0], 1'b1};

      rxValid <= 1'b0;
      if (ctl.clearData) begin
        bitCnt <= '0;
      end else if (ctl.shiftData) begin
        dataSh <= {dataSh[5:0], dat0};
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          rxByte  <= {dataSh, dat0};
          rxValid <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (ctl.driveFrame)   cmdOut = frameSh[FRAME_LEN-1];
    else if (ctl.holdLow) cmdOut = 1'b0;
    else                  cmdOut = 1'b1;
  end

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.driveFrame) |-> !cmdOut);

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.driveFrame) |-> $past(cmdOut));

  // R3
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/emmc_boot_ctrl.sv
module emmc_boot_ctrl
  import emmc_boot_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int BLK_W       = 8,
  parameter int TO_W        = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             bootOp,
  input  logic             altMode,
  input  logic             ackEn,
  input  logic [BLK_W-1:0] blockCount,
  input  logic [TO_W-1:0]  ackTimeout,
  input  logic             softTerm,
  input  logic             dat0,
  output dpCtlT            ctl,
  output logic             done,
  output logic             err
);

  localparam int BLOCK_BITS = BLOCK_BYTES * 8;
  localparam int BIT_W      = $clog2(BLOCK_BITS);
  localparam int CNT_W      = (BIT_W > TO_W) ? BIT_W : TO_W;

  seqStateT         state;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blkLeft;
  logic [2:0]       ackSh;
  logic             ackLat;
  logic             primLat;
  logic             termPrev;
  logic             termEdge;

  assign termEdge = softTerm && !termPrev;
  assign done     = (state == S_DONE);

  always_comb begin
    ctl            = '0;
    ctl.loadFrame  = (state == S_IDLE) && start && bootOp && altMode;
    ctl.shiftFrame = (state == S_CMD);
    ctl.driveFrame = (state == S_CMD);
    ctl.holdLow    = primLat && (state != S_IDLE);
    ctl.clearData  = (state == S_BLKWAIT) && !dat0;
    ctl.shiftData  = (state == S_DATA) && !termEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      blkLeft  <= '0;
      ackSh    <= '0;
      ackLat   <= 1'b0;
      primLat  <= 1'b0;
      termPrev <= 1'b0;
      err      <= 1'b0;
    end else begin
      termPrev <= softTerm;
      if (state != S_IDLE && termEdge) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            err     <= 1'b0;
            cnt     <= '0;
            ackLat  <= bootOp && ackEn;
            primLat <= bootOp && !altMode;
            blkLeft <= (blockCount == '0) ? BLK_W'(1) : blockCount;
            if (bootOp && altMode)    state <= S_CMD;
            else if (bootOp && ackEn) state <= S_ACKWAIT;
            else                      state <= S_BLKWAIT;
          end
          S_CMD: begin
            if (cnt == CNT_W'(FRAME_LEN - 1)) begin
              cnt   <= '0;
              state <= ackLat ? S_ACKWAIT : S_BLKWAIT;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_ACKWAIT: begin
            if (!dat0) begin
              cnt   <= '0;
              state <= S_ACKBITS;
            end else if ((cnt + CNT_W'(1)) == CNT_W'(ackTimeout)) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_ACKBITS: begin
            ackSh <= {ackSh[1:0], dat0};
            if (cnt == CNT_W'(3)) begin
              cnt <= '0;
              if ({ackSh, dat0} == 4'b0101) begin
                state <= S_BLKWAIT;
              end else begin
                err   <= 1'b1;
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_BLKWAIT: if (!dat0) begin
            cnt   <= '0;
            state <= S_DATA;
          end
          S_DATA: begin
            if (cnt == CNT_W'(BLOCK_BITS - 1)) begin
              cnt <= '0;
              if (blkLeft == BLK_W'(1)) begin
                state <= S_DONE;
              end else begin
                blkLeft <= blkLeft - BLK_W'(1);
                state   <= S_BLKWAIT;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_DONE:  state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> !done);

  // R7
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACKWAIT) |-> ackLat);

endmodule

// File: rtl/emmc_boot_seq.sv
module emmc_boot_seq
  import emmc_boot_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int BLK_W       = 8,
  parameter int TO_W        = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             bootOp,
  input  logic             altMode,
  input  logic             ackEn,
  input  logic [BLK_W-1:0] blockCount,
  input  logic [TO_W-1:0]  ackTimeout,
  input  logic             softTerm,
  input  logic             dat0,
  output logic             cmdOut,
  output logic [7:0]       rxByte,
  output logic             rxValid,
  output logic             done,
  output logic             err
);

  dpCtlT ctl;

  emmc_boot_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .BLK_W      (BLK_W),
    .TO_W       (TO_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .bootOp    (bootOp),
    .altMode   (altMode),
    .ackEn     (ackEn),
    .blockCount(blockCount),
    .ackTimeout(ackTimeout),
    .softTerm  (softTerm),
    .dat0      (dat0),
    .ctl       (ctl),
    .done      (done),
    .err       (err)
  );

  emmc_boot_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .dat0   (dat0),
    .cmdOut (cmdOut),
    .rxByte (rxByte),
    .rxValid(rxValid)
  );

endmodule

// File: tb/tb_emmc_boot_seq.sv
module tb_emmc_boot_seq;

  localparam int BLOCK_BYTES = 512;

  logic       clk = 1'b0;
  logic       rstN, start, bootOp, altMode, ackEn, softTerm, dat0;
  logic [7:0] blockCount;
  logic [15:0] ackTimeout;
  logic       cmdOut, rxValid, done, err;
  logic [7:0] rxByte;

  // 8 ns period, 125 MHz
  always #4 clk = ~clk;

  emmc_boot_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .bootOp(bootOp), .altMode(altMode),
    .ackEn(ackEn), .blockCount(blockCount), .ackTimeout(ackTimeout),
    .softTerm(softTerm), .dat0(dat0), .cmdOut(cmdOut), .rxByte(rxByte),
    .rxValid(rxValid), .done(done), .err(err)
  );

  int total = 0;
  int bad = 0;
  int doneCnt = 0;
  logic [7:0] expQ[$];
  logic [7:0] monExp;
  logic [47:0] frm;
  bit chkCmd = 0;
  bit chkErr0 = 0;
  logic cmdExp = 1'b1;
  string cmdTag = "";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input logic [39:0] m);
    logic [6:0] r = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = m[i] ^ r[6];
      r = {r[5:0], 1'b0} ^ (f ? 7'b0001001 : 7'b0);
    end
    return r;
  endfunction

  function automatic logic [47:0] refFrame();
    logic [39:0] m = {1'b0, 1'b1, 6'b0, 32'hFFFFFFFA};
    return {m, refCrc(m), 1'b1};
  endfunction

  // byte and done monitor
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (done) doneCnt++;
      if (rxValid) begin
        if (expQ.size() == 0) chk(0, "R3/R8 unexpected byte", rxByte, 0);
        else begin
          monExp = expQ.pop_front();
          chk(rxByte == monExp, "R3 byte value", rxByte, monExp);
        end
      end
    end
  end

  task automatic tick(input logic b);
    @(negedge clk);
    start = 1'b0;
    if (chkErr0) begin
      chk(err == 1'b0, "R9 err cleared by start", err, 0);
      chkErr0 = 0;
    end
    if (chkCmd) chk(cmdOut == cmdExp, cmdTag, cmdOut, cmdExp);
    dat0 = b;
  endtask

  task automatic sendBlocks(input int n, input bit prim);
    for (int b = 0; b < n; b++) begin
      repeat ($urandom_range(1, 6)) tick(1'b1);
      tick(1'b0);
      for (int k = 0; k < BLOCK_BYTES; k++) begin
        logic [7:0] v = 8'($urandom);
        expQ.push_back(v);
        for (int i = 7; i >= 0; i--) tick(v[i]);
      end
    end
    chkCmd = 0;
    @(negedge clk);
    dat0 = 1'b1;
    chk(done == 1'b1, "R9 done after last bit", done, 1);
    if (prim) chk(cmdOut == 1'b0, "R1 cmd low while done", cmdOut, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(cmdOut == 1'b1, "R1 cmd released at end", cmdOut, 1);
    chk(expQ.size() == 0, "R3 all bytes delivered", expQ.size(), 0);
  endtask

  // mode 0 normal, 1 ack timeout, 2 bad ack pattern
  task automatic doOp(input bit alt, input bit boot, input bit ack, input int bc,
                      input int nBlk, input int ackDelay, input logic [3:0] pat,
                      input int to, input int mode);
    bit prim = boot && !alt;
    @(negedge clk);
    altMode = alt; bootOp = boot; ackEn = ack;
    blockCount = 8'(bc); ackTimeout = 16'(to);
    start = 1'b1; dat0 = 1'b1;
    chkErr0 = 1;
    chkCmd = 0;
    if (boot && alt) begin
      for (int k = 1; k <= 48; k++) begin
        tick(1'b1);
        chk(cmdOut == frm[48-k], "R2 frame bit", cmdOut, frm[48-k]);
      end
    end
    cmdExp = prim ? 1'b0 : 1'b1;
    cmdTag = prim ? "R1 cmd held low" : (boot ? "R2 cmd high after frame" : "R7 cmd high in plain read");
    chkCmd = 1;
    if (boot && ack) begin
      if (mode == 1) begin
        for (int j = 0; j < to; j++) tick(1'b1);
        chk(err == 1'b0, "R5 no error before limit", err, 0);
        chkCmd = 0;
        @(negedge clk);
        chk(err == 1'b1, "R5 timeout error", err, 1);
        chk(cmdOut == 1'b1, "R5 cmd released", cmdOut, 1);
        chk(done == 1'b0, "R5 no done", done, 0);
        repeat (4) @(negedge clk);
        return;
      end
      repeat (ackDelay) tick(1'b1);
      tick(1'b0);
      for (int i = 3; i >= 0; i--) tick(pat[i]);
      if (mode == 2) begin
        chkCmd = 0;
        @(negedge clk);
        dat0 = 1'b1;
        chk(err == 1'b1, "R6 bad pattern error", err, 1);
        chk(cmdOut == 1'b1, "R6 cmd released", cmdOut, 1);
        repeat (4) @(negedge clk);
        return;
      end
    end
    sendBlocks(nBlk, prim);
    chk(err == 1'b0, "R4 no error on good run", err, 0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int d0;
    void'($urandom(32'd1234));
    frm = refFrame();
    rstN = 1'b0; start = 1'b0; bootOp = 1'b0; altMode = 1'b0; ackEn = 1'b0;
    softTerm = 1'b0; dat0 = 1'b1; blockCount = '0; ackTimeout = '0;
    repeat (3) @(negedge clk);
    chk(cmdOut == 1'b1, "R1 reset cmd high", cmdOut, 1);
    chk(done == 1'b0, "R9 reset done low", done, 0);
    chk(err == 1'b0, "R5 reset err low", err, 0);
    chk(rxValid == 1'b0, "R3 reset valid low", rxValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // alternate entry with acknowledge
    doOp(1, 1, 1, 1, 1, 3, 4'b0101, 16, 0);
    // primary entry, two blocks, no acknowledge
    doOp(0, 1, 0, 2, 2, 0, 4'b0101, 16, 0);
    // block count zero reads one block, ack at zero delay (R3, R4)
    doOp(0, 1, 1, 0, 1, 0, 4'b0101, 8, 0);
    // ack on the last accepted cycle (R4)
    doOp(0, 1, 1, 1, 1, 9, 4'b0101, 10, 0);
    // ack timeout (R5)
    doOp(0, 1, 1, 1, 0, 0, 4'b0101, 20, 1);
    // malformed ack (R6)
    doOp(1, 1, 1, 1, 0, 2, 4'b0111, 16, 2);
    // plain read ignores mode and ack enable (R7)
    doOp(1, 0, 1, 1, 1, 0, 4'b0101, 16, 0);

    // soft terminate mid block (R8)
    @(negedge clk);
    altMode = 1'b0; bootOp = 1'b1; ackEn = 1'b0; blockCount = 8'd1;
    start = 1'b1; dat0 = 1'b1;
    cmdExp = 1'b0; cmdTag = "R1 cmd held low"; chkCmd = 1;
    repeat (3) tick(1'b1);
    tick(1'b0);
    for (int k = 0; k < 125; k++) begin
      logic [7:0] v = 8'($urandom);
      expQ.push_back(v);
      for (int i = 7; i >= 0; i--) tick(v[i]);
    end
    chkCmd = 0;
    d0 = doneCnt;
    @(negedge clk);
    softTerm = 1'b1; dat0 = 1'($urandom);
    @(negedge clk);
    chk(cmdOut == 1'b1, "R8 cmd released on terminate", cmdOut, 1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      dat0 = 1'($urandom);
    end
    @(negedge clk);
    dat0 = 1'b1;
    chk(doneCnt == d0, "R8 no done after terminate", doneCnt, d0);
    chk(expQ.size() == 0, "R8 bytes before terminate", expQ.size(), 0);
    // held high: next operation completes
    d0 = doneCnt;
    doOp(1, 1, 0, 1, 1, 0, 4'b0101, 16, 0);
    chk(doneCnt == d0 + 1, "R8 level does not terminate", doneCnt, d0 + 1);
    @(negedge clk);
    softTerm = 1'b0;

    // random boot runs
    for (int r = 0; r < 4; r++) begin
      bit ra = 1'($urandom);
      bit rk = 1'($urandom);
      int nb = $urandom_range(1, 2);
      int to = $urandom_range(8, 40);
      int dl = $urandom_range(0, to - 1);
      doOp(ra, 1, rk, nb, nb, dl, 4'b0101, to, 0);
    end

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule